// File: doc/BRIEF.md
# Two-Level Packet Serializer

This block turns a 64-bit parallel packet into a single serial bit stream. A new packet arrives once every four sample clocks and leaves at sixteen bits per sample clock, so one packet fills exactly four sample periods on the line. With a 250 MHz sample clock the line rate is 4 Gbps.

Serialization happens in two levels. A byte selector walks through the packet's eight bytes, starting with the most significant. Each chosen byte goes into a small shifter built from two 4-stage chains. One chain holds the byte's even-position bits and the other its odd-position bits. In silicon the two chains would shift on opposite phases of a half-rate clock. Here they are modelled with a full-rate bit clock and a phase select that alternates between the chains, so the bit order is the same as the dual-edge version.

A load strobe is accepted only when the serializer is idle, or when it sits at the last bit of the current packet, which lets packets run back to back with no gap. A strobe that arrives at any other time is dropped and raises a one-cycle overrun flag.

Top module: `pkt_serializer`

## Requirements
- R1: A synchronous reset (rst high at a clock edge) forces ser_out and overrun low from the next cycle and cancels any packet in flight. ser_out stays low until a packet is loaded.
- R2: Packet bits leave MSB first. pkt_in[63] goes first and pkt_in[0] last. Bytes go from bits 63:56 down to bits 7:0, and within each byte the higher-numbered bit goes first.
- R3: When a strobe is accepted at clock edge N, the packet's first bit appears on ser_out after edge N+1. One further bit follows after each later edge, for 64 consecutive cycles.
- R4: While the serializer is idle, a load strobe is accepted on any clock edge. No alignment to a byte or sample boundary is required.
- R5: A strobe sampled while ser_out is showing bit 1 of the running packet is accepted. The next packet's bit 63 then directly follows the current packet's bit 0, with no gap cycle.
- R6: A strobe sampled at any other point during a packet is ignored, and the running stream continues unchanged. The strobe raises overrun for exactly the one cycle after that edge.
- R7: When a packet ends and no new strobe was accepted, ser_out is low from the cycle after bit 0 until the next accepted packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Full-rate bit clock |
| rst | input | 1 | Synchronous active-high reset |
| load | input | 1 | Packet load strobe |
| pkt_in | input | 64 | Parallel packet, sampled when a strobe is accepted |
| ser_out | output | 1 | Registered serial data, MSB first |
| overrun | output | 1 | One-cycle pulse after a strobe that was refused |

## Verification
Accepting a packet takes one edge, and the first bit then shows on ser_out one edge later. Overrun and the reset effects are each due on the edge right after the strobe or the reset that causes them. The bench uses a behavioural model of the bit index and packet that advances on the same edge as the design's inputs are sampled. Each expected value is compared 1 ns after every rising edge, so every result is checked in exactly the cycle it is due. Strobes for back-to-back packets are timed from the model's own bit index, not from anything inside the design.

// File: rtl/ser_pkg.sv
package ser_pkg;
  typedef enum logic {
    PH_EVEN = 1'b0,
    PH_ODD  = 1'b1
  } phase_e;
endpackage

// File: rtl/ser_ctrl.sv
module ser_ctrl #(
  parameter int PKT_W  = 64,
  parameter int BYTE_W = 8,
  localparam int CW    = $clog2(PKT_W),
  localparam int PHW   = $clog2(BYTE_W),
  localparam int BSW   = CW - PHW
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           load,
  output logic           active,
  output logic [CW-1:0]  bit_cnt,
  output logic           accept,
  output logic           byte_end,
  output logic [BSW-1:0] next_sel,
  output logic           overrun
);
  localparam logic [CW-1:0]  LAST     = CW'(PKT_W - 1);
  localparam logic [PHW-1:0] BYTE_TOP = PHW'(BYTE_W - 1);

  logic at_last;

  always_comb begin
    at_last  = active && (bit_cnt == LAST);
    accept   = load && (!active || at_last);
    byte_end = active && (bit_cnt[PHW-1:0] == BYTE_TOP) && !at_last;
    next_sel = bit_cnt[CW-1:PHW] + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active  <= 1'b0;
      bit_cnt <= '0;
      overrun <= 1'b0;
    end else begin
      overrun <= load && active && !at_last;
      if (accept) begin
        active  <= 1'b1;
        bit_cnt <= '0;
      end else if (at_last) begin
        active  <= 1'b0;
        bit_cnt <= '0;
      end else if (active) begin
        bit_cnt <= bit_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/pkt_byte_sel.sv
module pkt_byte_sel #(
  parameter int PKT_W  = 64,
  parameter int BYTE_W = 8,
  localparam int NB    = PKT_W / BYTE_W,
  localparam int BSW   = $clog2(NB)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              capture,
  input  logic [PKT_W-1:0]  pkt_in,
  input  logic [BSW-1:0]    sel,
  output logic [BYTE_W-1:0] byte_out
);
  logic [PKT_W-1:0]  pkt_q;
  logic [BYTE_W-1:0] lanes [NB];

  always_ff @(posedge clk) begin
    if (rst)          pkt_q <= '0;
    else if (capture) pkt_q <= pkt_in;
  end

  // Lane 0 is the most significant byte, so the select counts up from the top.
  for (genvar g = 0; g < NB; g++) begin : g_lane
    assign lanes[g] = pkt_q[PKT_W-1-g*BYTE_W -: BYTE_W];
  end

  assign byte_out = lanes[sel];
endmodule

// File: rtl/dual_chain_shifter.sv
module dual_chain_shifter
  import ser_pkg::*;
#(
  parameter int BYTE_W = 8,
  localparam int HALF  = BYTE_W / 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fill,
  input  logic [BYTE_W-1:0] fill_byte,
  input  logic              run,
  input  phase_e            phase,
  output logic              ser_out
);
  logic ev [HALF];
  logic od [HALF];
  logic ser_q;

  for (genvar g = 0; g < HALF; g++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) begin
        ev[g] <= 1'b0;
        od[g] <= 1'b0;
      end else if (fill) begin
        ev[g] <= fill_byte[BYTE_W-1-2*g];
        od[g] <= fill_byte[BYTE_W-2-2*g];
      end else if (run) begin
        if (phase == PH_EVEN) begin
          if (g == HALF-1) ev[g] <= 1'b0;
          else             ev[g] <= ev[(g+1)%HALF];
        end else begin
          if (g == HALF-1) od[g] <= 1'b0;
          else             od[g] <= od[(g+1)%HALF];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)      ser_q <= 1'b0;
    else if (run) ser_q <= (phase == PH_ODD) ? od[0] : ev[0];
    else          ser_q <= 1'b0;
  end

  assign ser_out = ser_q;
endmodule

// File: rtl/pkt_serializer.sv
module pkt_serializer
  import ser_pkg::*;
#(
  parameter int PKT_W  = 64,
  parameter int BYTE_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [PKT_W-1:0] pkt_in,
  output logic             ser_out,
  output logic             overrun
);
  localparam int CW  = $clog2(PKT_W);
  localparam int NB  = PKT_W / BYTE_W;
  localparam int BSW = $clog2(NB);

  logic              active;
  logic [CW-1:0]     bit_cnt;
  logic              accept;
  logic              byte_end;
  logic [BSW-1:0]    next_sel;
  logic [BYTE_W-1:0] sel_byte;
  logic [BYTE_W-1:0] fill_byte;
  phase_e            phase;

  ser_ctrl #(.PKT_W(PKT_W), .BYTE_W(BYTE_W)) u_ctrl (
    .clk(clk), .rst(rst), .load(load),
    .active(active), .bit_cnt(bit_cnt), .accept(accept),
    .byte_end(byte_end), .next_sel(next_sel), .overrun(overrun)
  );

  pkt_byte_sel #(.PKT_W(PKT_W), .BYTE_W(BYTE_W)) u_sel (
    .clk(clk), .rst(rst), .capture(accept), .pkt_in(pkt_in),
    .sel(next_sel), .byte_out(sel_byte)
  );

  // A freshly accepted packet feeds its top byte straight to the shifter.
  assign fill_byte = accept ? pkt_in[PKT_W-1 -: BYTE_W] : sel_byte;
  assign phase     = phase_e'(bit_cnt[0]);

  dual_chain_shifter #(.BYTE_W(BYTE_W)) u_shift (
    .clk(clk), .rst(rst), .fill(accept || byte_end), .fill_byte(fill_byte),
    .run(active), .phase(phase), .ser_out(ser_out)
  );
endmodule

// File: rtl/pkt_serializer_chk.sv
module pkt_serializer_chk #(
  parameter int CW = 6
) (
  input logic          clk,
  input logic          rst,
  input logic          load,
  input logic          ser_out,
  input logic          overrun,
  input logic          active,
  input logic [CW-1:0] bit_cnt
);
  localparam logic [CW-1:0] LAST = {CW{1'b1}};

  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (!ser_out && !overrun));

  a_r4_idle_accept: assert property (@(posedge clk) disable iff (rst)
    (load && !active) |=> (active && bit_cnt == '0));

  a_r5_wrap_reload: assert property (@(posedge clk) disable iff (rst)
    (load && active && bit_cnt == LAST) |=> (active && bit_cnt == '0));

  a_r6_strobe_ignored: assert property (@(posedge clk) disable iff (rst)
    (load && active && bit_cnt != LAST) |=> (active && bit_cnt == CW'($past(bit_cnt) + 1'b1)));

  a_r6_overrun_cause: assert property (@(posedge clk) disable iff (rst)
    overrun |-> ($past(load) && $past(active)));

  a_r7_end_idle: assert property (@(posedge clk) disable iff (rst)
    (active && bit_cnt == LAST && !load) |=> !active);

  a_r7_low_when_idle: assert property (@(posedge clk) disable iff (rst)
    ser_out |-> $past(active));
endmodule

bind pkt_serializer pkt_serializer_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst(rst), .load(load), .ser_out(ser_out),
  .overrun(overrun), .active(active), .bit_cnt(bit_cnt)
);

// File: tb/test_pkt_serializer.sv
`timescale 1ns/1ps
module test_pkt_serializer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        load = 1'b0;
  logic [63:0] pkt_in = '0;
  logic        ser_out;
  logic        overrun;

  int checks = 0;
  int fails  = 0;

  // behavioural model state
  bit          m_act = 0;
  int          m_idx = 0;
  logic [63:0] m_pkt = '0;
  logic        exp_out, exp_ovr;

  always #2 clk = ~clk;

  pkt_serializer i_pkt_serializer (
    .clk(clk), .rst(rst), .load(load), .pkt_in(pkt_in),
    .ser_out(ser_out), .overrun(overrun)
  );

  task automatic check(input string tag, input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: got %b expected %b at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic step(input bit r, input bit ld, input logic [63:0] p, input string tag);
    bit acc;
    @(negedge clk);
    rst = r; load = ld; pkt_in = p;
    @(posedge clk);
    #1;
    if (r) begin
      m_act = 0; m_idx = 0; exp_out = 1'b0; exp_ovr = 1'b0;
    end else begin
      exp_out = m_act ? m_pkt[63 - m_idx] : 1'b0;
      exp_ovr = ld && m_act && (m_idx != 63);
      acc = ld && (!m_act || m_idx == 63);
      if (acc) begin
        m_pkt = p; m_idx = 0; m_act = 1;
      end else if (m_act) begin
        if (m_idx == 63) m_act = 0;
        else m_idx++;
      end
    end
    check(tag, ser_out, exp_out, "ser_out");
    check(tag, overrun, exp_ovr, "overrun");
  endtask

  function automatic logic [63:0] rnd64();
    return {$urandom(), $urandom()};
  endfunction

  task automatic run_idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(0, 0, rnd64(), tag);
  endtask

  initial begin
    logic [63:0] d;
    // R1: reset state
    for (int i = 0; i < 3; i++) step(1, 0, '0, "R1");
    run_idle(4, "R1");

    // R3: a single set MSB appears on the second edge after the strobe
    step(0, 1, 64'h8000_0000_0000_0000, "R3");
    run_idle(70, "R3");

    // R2: byte order and in-byte order with distinct bytes
    step(0, 1, 64'hF1E2_D3C4_B5A6_9788, "R2");
    run_idle(66, "R2");

    // R4: load at odd idle offsets
    run_idle(3, "R4");
    step(0, 1, 64'h0123_4567_89AB_CDEF, "R4");
    run_idle(67, "R7");

    // R5: back-to-back packets, strobe timed from the model's bit index
    step(0, 1, rnd64(), "R5");
    for (int k = 0; k < 4; k++) begin
      while (!(m_act && m_idx == 63)) step(0, 0, rnd64(), "R5");
      step(0, 1, rnd64(), "R5");
    end
    run_idle(66, "R7");

    // R6: mid-packet strobes are ignored
    step(0, 1, 64'hAAAA_5555_FF00_0FF0, "R6");
    run_idle(10, "R6");
    step(0, 1, 64'hFFFF_FFFF_FFFF_FFFF, "R6");
    step(0, 1, 64'h0, "R6");
    run_idle(30, "R6");
    while (!(m_act && m_idx == 60)) step(0, 0, rnd64(), "R6");
    step(0, 1, rnd64(), "R6");
    run_idle(8, "R7");

    // R1: reset in the middle of a packet
    step(0, 1, 64'hFFFF_FFFF_FFFF_FFFF, "R1");
    run_idle(20, "R1");
    step(1, 1, 64'hFFFF_FFFF_FFFF_FFFF, "R1");
    run_idle(10, "R1");

    // R2: random packets, random gaps
    for (int k = 0; k < 12; k++) begin
      d = rnd64();
      step(0, 1, d, "R2");
      run_idle(63 + ($urandom() % 4), "R2");
    end
    run_idle(5, "R7");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(200000 * 4);
    fails++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule